// File: doc/BRIEF.md
# Flash Completion Poller

This block sits on the host side of a parallel flash. It accepts one program or erase request at a time, sends a one-cycle launch pulse toward the flash command logic, and then works out when the flash has finished by reading status back from the target address. Two detection methods are selectable per request. In data mode the poll bit (bit 7) is compared with the expected value. After a program the expected value is bit 7 of the written byte, and after an erase it is 1. In toggle mode the toggle bit (bit 6) must read the same in two consecutive reads.

Polling begins right after the launch, with no initial wait. Each poll is a read cycle followed by an evaluate cycle. Once the operation is complete, one more read fetches the final byte, which is returned alongside a one-cycle done pulse. A per-request poll limit bounds the wait. When the limit is reached while the flash still reads busy, a one-cycle timeout pulse is raised in place of done. In both cases the block then returns to idle.

The request side is a valid/ready handshake. `req_ready` is high only while the block is idle. A request transfers on a cycle where both `req_valid` and `req_ready` are high, and `req_valid` is ignored while the block is busy. The launch, read, done and timeout pins are plain strobes with no back-pressure.

Top module: `flash_done_poller`

## Requirements
- R1: After reset `req_ready` is 1 and `cmd_valid`, `rd_en`, `done` and `timeout` are 0.
- R2: A request is taken only on a cycle where `req_valid` and `req_ready` are both 1. `req_ready` is 0 from the cycle after acceptance until the operation ends, and `req_valid` or request fields presented during that time have no effect.
- R3: In the cycle after acceptance `cmd_valid` is 1 for exactly one cycle. During that cycle `cmd_erase`, `cmd_addr` and `cmd_data` carry the accepted request, where `req_erase` = 0 means program and 1 means erase.
- R4: The first status read (`rd_en` = 1, `rd_addr` = accepted address) is issued in the cycle right after the launch cycle. `rd_data` is valid one cycle after `rd_en`, and further status reads follow every second cycle.
- R5: With `req_toggle` = 0 and a program, a status read is complete when its bit 7 equals bit 7 of the written byte.
- R6: With `req_toggle` = 0 and an erase, a status read is complete when bit 7 is 1 and busy when bit 7 is 0.
- R7: With `req_toggle` = 1, the first status read always counts as busy. Each later read is complete when its bit 6 equals bit 6 of the previous status read, and busy otherwise.
- R8: After a complete status read, one more read of the same address is issued two cycles later. `done` is 1 for exactly one cycle two cycles after that read, and `result_data` then equals the byte it returned.
- R9: Status reads are numbered from 1. A busy read whose number is at least max(1, `poll_limit`) ends the operation: `timeout` is 1 for one cycle, one cycle after that read's evaluate cycle, and `done` stays 0.
- R10: `req_ready` is 1 again in the cycle after `done` or `timeout`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request can transfer |
| req_erase | input | 1 | 0 program, 1 erase |
| req_toggle | input | 1 | 0 data (bit 7) polling, 1 toggle (bit 6) polling |
| req_addr | input | AW | Target address |
| req_data | input | DW | Byte to program |
| poll_limit | input | CW | Maximum status reads, sampled at acceptance |
| cmd_valid | output | 1 | One-cycle launch pulse to flash command logic |
| cmd_erase | output | 1 | Launch is an erase |
| cmd_addr | output | AW | Launch address |
| cmd_data | output | DW | Launch data |
| rd_en | output | 1 | Read strobe toward flash |
| rd_addr | output | AW | Read address |
| rd_data | input | DW | Read data, valid the cycle after rd_en |
| done | output | 1 | One-cycle completion pulse |
| timeout | output | 1 | One-cycle poll-limit pulse |
| result_data | output | DW | Final byte read after completion, valid with done |

## Verification
The assertions assume that the flash returns read data exactly one cycle after `rd_en`, that nothing but `cmd_valid` starts an operation, and that reset is applied before the first request. The bench meets these conditions with a flash model that registers every read once. Its busy window is armed only by the launch pulse. During the busy window it inverts bit 7 for a program, holds bit 7 low for an erase, and flips bit 6 on every read. Busy lengths are chosen so that toggle mode sees the final data both match and differ from the last toggled value. Poll limits of 0, 1 and small values force timeouts on the first and later reads.

// File: rtl/fdp_pkg.sv
`timescale 1ns/1ps
package fdp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_LAUNCH, ST_POLL_RD, ST_POLL_EV,
    ST_FIN_RD, ST_FIN_EV, ST_DONE, ST_TOUT
  } fdp_state_e;
endpackage

// File: rtl/fdp_status_eval.sv
`timescale 1ns/1ps
module fdp_status_eval (
  input  logic toggle_mode,
  input  logic erase_op,
  input  logic want_bit,
  input  logic rd_poll_bit,
  input  logic rd_tog_bit,
  input  logic prev_valid,
  input  logic prev_tog,
  output logic finished
);
  always_comb begin
    if (toggle_mode)
      finished = prev_valid && (rd_tog_bit == prev_tog);
    else if (erase_op)
      finished = rd_poll_bit;
    else
      finished = (rd_poll_bit == want_bit);
  end
endmodule

// File: rtl/fdp_poll_counter.sv
`timescale 1ns/1ps
module fdp_poll_counter #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          tick,
  input  logic [CW-1:0] limit,
  output logic          last_poll
);
  logic [CW-1:0] cnt_q;
  logic [CW:0]   this_num;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (clear) cnt_q <= '0;
    else if (tick)  cnt_q <= cnt_q + 1'b1;
  end

  // number of the status read currently being evaluated
  assign this_num  = {1'b0, cnt_q} + 1'b1;
  assign last_poll = (this_num >= {1'b0, limit});

  p_count_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (cnt_q == '0));
endmodule

// File: rtl/flash_done_poller.sv
`timescale 1ns/1ps
module flash_done_poller #(
  parameter int AW       = 8,
  parameter int DW       = 8,
  parameter int CW       = 8,
  parameter int POLL_BIT = 7,
  parameter int TOG_BIT  = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_erase,
  input  logic          req_toggle,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_data,
  input  logic [CW-1:0] poll_limit,
  output logic          cmd_valid,
  output logic          cmd_erase,
  output logic [AW-1:0] cmd_addr,
  output logic [DW-1:0] cmd_data,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  input  logic [DW-1:0] rd_data,
  output logic          done,
  output logic          timeout,
  output logic [DW-1:0] result_data
);
  import fdp_pkg::*;

  fdp_state_e    state_q;
  logic          erase_q, toggle_q, prev_valid_q, prev_tog_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q, result_q;
  logic [CW-1:0] limit_q;
  logic          finished, last_poll, accept;

  assign accept = req_valid && (state_q == ST_IDLE);

  fdp_status_eval u_eval (
    .toggle_mode (toggle_q),
    .erase_op    (erase_q),
    .want_bit    (data_q[POLL_BIT]),
    .rd_poll_bit (rd_data[POLL_BIT]),
    .rd_tog_bit  (rd_data[TOG_BIT]),
    .prev_valid  (prev_valid_q),
    .prev_tog    (prev_tog_q),
    .finished    (finished)
  );

  fdp_poll_counter #(.CW(CW)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (state_q == ST_LAUNCH),
    .tick      (state_q == ST_POLL_EV),
    .limit     (limit_q),
    .last_poll (last_poll)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      erase_q      <= 1'b0;
      toggle_q     <= 1'b0;
      addr_q       <= '0;
      data_q       <= '0;
      limit_q      <= '0;
      prev_valid_q <= 1'b0;
      prev_tog_q   <= 1'b0;
      result_q     <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept) begin
          erase_q      <= req_erase;
          toggle_q     <= req_toggle;
          addr_q       <= req_addr;
          data_q       <= req_data;
          limit_q      <= poll_limit;
          prev_valid_q <= 1'b0;
          state_q      <= ST_LAUNCH;
        end
        ST_LAUNCH:  state_q <= ST_POLL_RD;
        ST_POLL_RD: state_q <= ST_POLL_EV;
        ST_POLL_EV: begin
          prev_valid_q <= 1'b1;
          prev_tog_q   <= rd_data[TOG_BIT];
          if (finished)       state_q <= ST_FIN_RD;
          else if (last_poll) state_q <= ST_TOUT;
          else                state_q <= ST_POLL_RD;
        end
        ST_FIN_RD: state_q <= ST_FIN_EV;
        ST_FIN_EV: begin
          result_q <= rd_data;
          state_q  <= ST_DONE;
        end
        ST_DONE: state_q <= ST_IDLE;
        ST_TOUT: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready   = (state_q == ST_IDLE);
  assign cmd_valid   = (state_q == ST_LAUNCH);
  assign cmd_erase   = erase_q;
  assign cmd_addr    = addr_q;
  assign cmd_data    = data_q;
  assign rd_en       = (state_q == ST_POLL_RD) || (state_q == ST_FIN_RD);
  assign rd_addr     = addr_q;
  assign done        = (state_q == ST_DONE);
  assign timeout     = (state_q == ST_TOUT);
  assign result_data = result_q;

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_launch_then_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> rd_en);
  p_busy_not_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en || cmd_valid) |-> !req_ready);
  p_end_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && timeout));
  p_ready_after_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (done || timeout) |=> req_ready);
  p_launch_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);
endmodule

// File: tb/test_flash_done_poller.sv
`timescale 1ns/1ps
module test_flash_done_poller;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       req_valid = 1'b0, req_erase = 1'b0, req_toggle = 1'b0;
  logic [7:0] req_addr = '0, req_data = '0, poll_limit = '0;
  logic       req_ready, cmd_valid, cmd_erase, rd_en, done, timeout;
  logic [7:0] cmd_addr, cmd_data, rd_addr, rd_data, result_data;

  int compared = 0, mismatched = 0;
  bit finished_run = 0;

  always #5 clk = ~clk;

  flash_done_poller i_flash_done_poller (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_erase(req_erase), .req_toggle(req_toggle), .req_addr(req_addr),
    .req_data(req_data), .poll_limit(poll_limit), .cmd_valid(cmd_valid),
    .cmd_erase(cmd_erase), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .done(done),
    .timeout(timeout), .result_data(result_data));

  // flash model: busy window armed by the launch pulse
  logic [7:0] mem [256];
  int         busy_left = 0, busy_set = 0;
  logic       f_erase = 1'b0, f_tg = 1'b0;
  logic [7:0] f_data = '0, rd_q = '0;
  assign rd_data = rd_q;

  always @(posedge clk) begin
    if (cmd_valid) begin
      busy_left <= busy_set;
      f_tg      <= 1'b0;
      f_erase   <= cmd_erase;
      f_data    <= cmd_data;
      mem[cmd_addr] <= cmd_erase ? 8'hFF : cmd_data;
    end else if (rd_en) begin
      if (busy_left > 0) begin
        rd_q      <= {f_erase ? 1'b0 : ~f_data[7], ~f_tg, 6'h15};
        f_tg      <= ~f_tg;
        busy_left <= busy_left - 1;
      end else begin
        rd_q <= mem[rd_addr];
      end
    end
  end

  // reference model state
  bit         m_active = 0, m_comp = 0;
  int         m_c = 0, m_k = 0, m_end = 0;
  logic       m_erase = 1'b0;
  logic [7:0] m_addr = '0, m_data = '0, m_final = '0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // walk the status reads the flash model will return and apply the rules
  task automatic plan_req(input bit er, input bit tg, input logic [7:0] d,
                          input int b, input int lim, output int kk, output bit comp);
    bit pv = 0, pt = 0, fin;
    logic [7:0] v;
    int lim1 = (lim < 1) ? 1 : lim;
    kk = 0; comp = 0;
    for (int n = 1; n < 1000; n++) begin
      v = (n <= b) ? {er ? 1'b0 : ~d[7], n[0], 6'h15} : (er ? 8'hFF : d);
      if (tg)      fin = pv && (v[6] == pt);   // R7
      else if (er) fin = v[7];                 // R6
      else         fin = (v[7] == d[7]);       // R5
      if (fin)       begin kk = n; comp = 1; break; end
      if (n >= lim1) begin kk = n; comp = 0; break; end  // R9
      pv = 1; pt = v[6];
    end
  endtask

  task automatic compare();
    bit exp_rd, exp_done, exp_to;
    exp_rd   = m_active && ((m_c >= 2 && m_c <= 2*m_k && m_c % 2 == 0) ||
                            (m_comp && m_c == 2*m_k + 2));
    exp_done = m_active && m_comp && (m_c == 2*m_k + 4);
    exp_to   = m_active && !m_comp && (m_c == 2*m_k + 2);
    chk("R2/R10", "req_ready", req_ready, !m_active);
    chk("R3", "cmd_valid", cmd_valid, m_active && m_c == 1);
    chk("R4", "rd_en", rd_en, exp_rd);
    chk("R8", "done", done, exp_done);
    chk("R9", "timeout", timeout, exp_to);
    if (m_active && m_c == 1) begin
      chk("R3", "cmd_erase", cmd_erase, m_erase);
      chk("R3", "cmd_addr", cmd_addr, m_addr);
      chk("R3", "cmd_data", cmd_data, m_data);
    end
    if (exp_rd) chk("R4", "rd_addr", rd_addr, m_addr);
    if (exp_done) chk("R8", "result_data", result_data, m_final);
  endtask

  task automatic cycle();
    @(negedge clk);
    compare();
    if (m_active) begin
      if (m_c == m_end) m_active = 0;
      else m_c++;
    end
  endtask

  task automatic run_req(input bit er, input bit tg, input logic [7:0] a,
                         input logic [7:0] d, input int lim, input int b, input int hold);
    req_erase = er; req_toggle = tg; req_addr = a; req_data = d;
    poll_limit = lim[7:0]; req_valid = 1'b1; busy_set = b;
    plan_req(er, tg, d, b, lim, m_k, m_comp);
    m_erase = er; m_addr = a; m_data = d; m_final = er ? 8'hFF : d;
    m_end = m_comp ? 2*m_k + 4 : 2*m_k + 2;
    m_active = 1; m_c = 1;
    for (int i = 0; m_active; i++) begin
      cycle();
      if (i < hold) begin  // R2: changed fields while busy are ignored
        req_erase = ~er; req_addr = ~a; req_data = ~d; poll_limit = 8'd1;
      end else begin
        req_valid = 1'b0;
      end
    end
    req_valid = 1'b0;
    cycle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished_run) begin
      mismatched++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    chk("R1", "req_ready in reset", req_ready, 1);
    chk("R1", "done in reset", done, 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    cycle(); cycle();                               // R1 idle after reset
    run_req(0, 0, 8'h10, 8'hA5, 20, 3, 0);          // R5 program, bit7=1
    run_req(0, 0, 8'h11, 8'h3C, 20, 0, 0);          // R5 program, ready at once
    run_req(0, 0, 8'h12, 8'h5A, 20, 5, 2);          // R5 + R2 hold during busy
    run_req(1, 0, 8'h20, 8'h00, 20, 4, 0);          // R6 erase
    run_req(0, 1, 8'h30, 8'h40, 20, 3, 0);          // R7 final matches last toggle
    run_req(0, 1, 8'h31, 8'h40, 20, 4, 1);          // R7 final differs, extra read
    run_req(1, 1, 8'h32, 8'h00, 20, 2, 0);          // R7 erase
    run_req(0, 1, 8'h33, 8'h00, 20, 0, 0);          // R7 not busy: two reads
    run_req(0, 0, 8'h40, 8'h81, 3, 10, 0);          // R9 timeout on third read
    run_req(0, 1, 8'h41, 8'h81, 1, 0, 0);           // R9 toggle first read limit 1
    run_req(1, 0, 8'h42, 8'h00, 0, 2, 0);           // R9 limit 0 acts as 1
    run_req(0, 0, 8'h43, 8'h7F, 4, 3, 0);           // R9 limit exactly reached? completes on 4th
    repeat (3) cycle();                              // R10 stays idle
    finished_run = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule